// File: doc/BRIEF.md
# Wide-to-Narrow Result Serializer

This block takes one wide result vector and hands it out as a run of narrow words. The vector comes from sixteen processing elements, each giving a 32-bit result, so it is 512 bits wide. The block emits it as eight 64-bit words. A load pulse captures the whole vector, and the most significant word shows on the output in the next cycle. After that, each accepted shift pulse moves the next lower word onto the output, until all eight words have been shown.

The block keeps a small record of its progress. A chunk index reports which word is on the output, counted from zero at the most significant end. A done flag rises when the last word is on the output. Once the frame is done, further shifts are ignored until the next load. A load always takes priority over a shift in the same cycle, and a load restarts the frame from any point. The consumer handshake and any other flow control are outside this block.

Top module: `wide_result_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself. After that edge, `data_out` is 0, `chunk_idx` is 0 and `frame_done` is 0.
- R2: A load captures `data_in` at the clock edge. From the next cycle, `data_out` equals `data_in[511:448]` as it was at that edge, `chunk_idx` is 0 and `frame_done` is 0.
- R3: A shift with no load, made while a frame is open (loaded and not done), moves the next lower 64-bit word of the captured vector onto `data_out` at the next edge and raises `chunk_idx` by one. Word k occupies bits [511-64k : 448-64k].
- R4: After the seventh accepted shift of a frame, `data_out` equals bits [63:0] of the captured vector, `chunk_idx` is 7 and `frame_done` is 1. `frame_done` is never high with `chunk_idx` below 7.
- R5: A shift while `frame_done` is high, with no load, leaves `data_out`, `chunk_idx` and `frame_done` unchanged.
- R6: When load and shift are high in the same cycle, the load acts and the shift is dropped: the result is the same as a load alone.
- R7: A shift after reset and before any load leaves `data_out` at 0 and `chunk_idx` at 0.
- R8: In a cycle with neither load nor shift, `data_out`, `chunk_idx` and `frame_done` keep their values.
- R9: A load made while a frame is partly sent discards that frame and starts a new one from its most significant word, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `data_in` and start a new frame |
| shift | input | 1 | Step to the next lower word of the frame |
| data_in | input | 512 | Result vector: sixteen 32-bit lanes |
| data_out | output | 64 | The word currently presented |
| chunk_idx | output | 3 | Index of the presented word, 0 for the most significant |
| frame_done | output | 1 | High once the least significant word is presented |

## Verification
Each frame is loaded with a random vector. Its words are then stepped out with random idle gaps between shifts, so that holding is told apart from stepping, and every presented word is compared with the slice the bench expects in most-significant-first order. Directed cases cover the corner cases. Shifts right after reset and extra shifts past the eighth word show whether stray shifts are ignored. A load and a shift in the same cycle, and a load in the middle of a frame, show whether the load takes priority and fully restarts the frame. Random vectors make a swapped slice or a wrong shift direction show up as a data mismatch instead of passing by chance.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  localparam int unsigned DEF_PE_COUNT = 16;
  localparam int unsigned DEF_PE_W     = 32;
  localparam int unsigned DEF_WORD_W   = 64;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_SHIFT = 2'd2
  } wrs_cmd_e;

endpackage

// File: rtl/wrs_cmd_decode.sv
module wrs_cmd_decode
  import wrs_pkg::*;
(
  input  logic     load,
  input  logic     shift,
  input  logic     frame_open,
  output wrs_cmd_e cmd
);

  // A load always wins. A shift acts only while a frame is open.
  always_comb begin
    if (load)
      cmd = CMD_LOAD;
    else if (shift && frame_open)
      cmd = CMD_SHIFT;
    else
      cmd = CMD_HOLD;
  end

endmodule

// File: rtl/wrs_chunk_ctrl.sv
module wrs_chunk_ctrl
  import wrs_pkg::*;
#(
  parameter int unsigned CHUNKS = 8,
  localparam int unsigned IDX_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  wrs_cmd_e         cmd,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             frame_open
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHUNKS - 1);

  logic [IDX_W-1:0] idx_next;
  assign idx_next = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      done       <= 1'b0;
      frame_open <= 1'b0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          idx        <= '0;
          done       <= (CHUNKS == 1);
          frame_open <= (CHUNKS > 1);
        end
        CMD_SHIFT: begin
          idx <= idx_next;
          if (idx_next == LAST) begin
            done       <= 1'b1;
            frame_open <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R4: done only with the last index on the output
  p_done_last_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (idx == LAST));

  // R2: a load restarts the index and clears done
  p_load_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (idx == '0) && (done == (CHUNKS == 1)));

  // R3: an accepted shift advances the index by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SHIFT) |=> (idx == IDX_W'($past(idx) + 1'b1)));

  // R5: with the frame closed and no load, index and done stay put
  p_closed_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!frame_open && cmd != CMD_LOAD) |=> ($stable(idx) && $stable(done)));

  // open and done are never both set
  p_open_done_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(frame_open && done));

endmodule

// File: rtl/wrs_shift_reg.sv
module wrs_shift_reg
  import wrs_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned CHUNKS = 8,
  localparam int unsigned VEC_W = WORD_W * CHUNKS
) (
  input  logic              clk,
  input  logic              rst,
  input  wrs_cmd_e          cmd,
  input  logic [VEC_W-1:0]  vec_in,
  output logic [WORD_W-1:0] word_out
);

  // word slot k holds bits [WORD_W*(k+1)-1 : WORD_W*k]; slot CHUNKS-1 is the top
  logic [WORD_W-1:0] slot [CHUNKS];

  for (genvar k = 0; k < CHUNKS; k++) begin : g_slot
    logic [WORD_W-1:0] shift_src;
    if (k == 0) begin : g_fill
      assign shift_src = '0;
    end else begin : g_move
      assign shift_src = slot[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot[k] <= '0;
      end else begin
        case (cmd)
          CMD_LOAD:  slot[k] <= vec_in[WORD_W*k +: WORD_W];
          CMD_SHIFT: slot[k] <= shift_src;
          default:   ;
        endcase
      end
    end
  end

  assign word_out = slot[CHUNKS-1];

  // R8: with no command the presented word does not move
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD) |=> $stable(word_out));

  // R3: a shift brings the slot below into the top position
  if (CHUNKS > 1) begin : g_chk_step
    p_word_step_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_SHIFT) |=> (word_out == $past(slot[CHUNKS-2])));
  end

endmodule

// File: rtl/wide_result_serializer.sv
module wide_result_serializer
  import wrs_pkg::*;
#(
  parameter int unsigned PE_COUNT = DEF_PE_COUNT,
  parameter int unsigned PE_W     = DEF_PE_W,
  parameter int unsigned WORD_W   = DEF_WORD_W,
  localparam int unsigned VEC_W   = PE_COUNT * PE_W,
  localparam int unsigned CHUNKS  = VEC_W / WORD_W,
  localparam int unsigned IDX_W   = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [VEC_W-1:0]  data_in,
  output logic [WORD_W-1:0] data_out,
  output logic [IDX_W-1:0]  chunk_idx,
  output logic              frame_done
);

  initial begin
    if (VEC_W % WORD_W != 0)
      $error("vector width must be a whole number of output words");
  end

  wrs_cmd_e cmd;
  logic     frame_open;

  wrs_cmd_decode u_decode (
    .load       (load),
    .shift      (shift),
    .frame_open (frame_open),
    .cmd        (cmd)
  );

  wrs_chunk_ctrl #(
    .CHUNKS (CHUNKS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .idx        (chunk_idx),
    .done       (frame_done),
    .frame_open (frame_open)
  );

  wrs_shift_reg #(
    .WORD_W (WORD_W),
    .CHUNKS (CHUNKS)
  ) u_sreg (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .vec_in   (data_in),
    .word_out (data_out)
  );

  // R2 / R6 / R9: a load presents the top word of the captured vector
  p_load_top_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (data_out == $past(data_in[VEC_W-1 -: WORD_W])) && (chunk_idx == '0));

  // R8: quiet inputs keep every output steady
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> ($stable(data_out) && $stable(chunk_idx) && $stable(frame_done)));

  // R5: shifts after the frame is done are ignored
  p_done_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !load) |=> ($stable(data_out) && frame_done));

endmodule

// File: tb/wide_result_serializer_tb_top.sv
`timescale 1ns/1ps
module wide_result_serializer_tb_top;

  localparam int VEC_W  = 512;
  localparam int WORD_W = 64;
  localparam int CHUNKS = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              load;
  logic              shift;
  logic [VEC_W-1:0]  data_in;
  logic [WORD_W-1:0] data_out;
  logic [2:0]        chunk_idx;
  logic              frame_done;

  always #2.5 clk = ~clk;

  wide_result_serializer dut_i (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .shift      (shift),
    .data_in    (data_in),
    .data_out   (data_out),
    .chunk_idx  (chunk_idx),
    .frame_done (frame_done)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  logic [VEC_W-1:0] m_vec;
  int               m_idx;
  bit               m_loaded;
  bit               m_done;

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(logic [VEC_W-1:0] v, int k, bit loaded);
    if (!loaded) return '0;
    return v[VEC_W-1-WORD_W*k -: WORD_W];
  endfunction

  task automatic check(string tag);
    logic [WORD_W-1:0] ew;
    ew = exp_word(m_vec, m_idx, m_loaded);
    n_run++;
    if (data_out !== ew || chunk_idx !== 3'(m_idx) || frame_done !== m_done) begin
      n_fail++;
      $display("FAIL %s: data_out=%h idx=%0d done=%0b expected data_out=%h idx=%0d done=%0b",
               tag, data_out, chunk_idx, frame_done, ew, m_idx, m_done);
    end
  endtask

  // drive one cycle at the falling edge, update the model, check at the next falling edge
  task automatic step(bit ld, bit sh, logic [VEC_W-1:0] v);
    string tag;
    load = ld; shift = sh; data_in = v;
    if (ld && sh)                    tag = "R6";
    else if (ld && m_loaded && !m_done && m_idx > 0) tag = "R9";
    else if (ld)                     tag = "R2";
    else if (sh && !m_loaded)        tag = "R7";
    else if (sh && m_done)           tag = "R5";
    else if (sh)                     tag = (m_idx == CHUNKS - 2) ? "R4" : "R3";
    else                             tag = "R8";
    if (ld) begin
      m_vec = v; m_idx = 0; m_loaded = 1; m_done = 0;
    end else if (sh && m_loaded && !m_done) begin
      m_idx++;
      if (m_idx == CHUNKS - 1) m_done = 1;
    end
    @(negedge clk);
    load = 0; shift = 0;
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1; load = 0; shift = 0; data_in = '0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_vec = '0; m_idx = 0; m_loaded = 0; m_done = 0;
    check("R1");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; load = 0; shift = 0; data_in = '0;
    @(negedge clk);
    do_reset();

    // R7: shifts before any load
    step(0, 1, rand_vec());
    step(0, 1, '0);

    // directed frame: load, all shifts, extra shifts (R2 R3 R4 R5)
    step(1, 0, rand_vec());
    step(0, 0, '0);
    for (int s = 0; s < CHUNKS - 1; s++) step(0, 1, '0);
    step(0, 1, '0);
    step(0, 1, rand_vec());

    // R6: load and shift together, mid frame and after done
    step(1, 1, rand_vec());
    step(0, 1, '0);
    step(0, 1, '0);
    step(1, 1, rand_vec());
    step(0, 1, '0);

    // R9: reload mid frame
    step(1, 0, rand_vec());
    step(0, 1, '0);
    step(0, 1, '0);
    step(0, 1, '0);

    // reset mid frame (R1)
    do_reset();

    // random frames with random gaps
    for (int f = 0; f < 40; f++) begin
      step(1, ($urandom % 4) == 0, rand_vec());
      for (int s = 0; s < CHUNKS + 2; s++) begin
        int gap = $urandom % 4;
        for (int g = 0; g < gap; g++) step(0, 0, rand_vec());
        if (($urandom % 16) == 0) step(1, 0, rand_vec());
        else step(0, 1, rand_vec());
      end
    end

    finish_run();
  end

endmodule